// File: doc/BRIEF.md
# Read-Address Sequence Command Detector

This block watches a memory-style bus that has already been sampled into the local clock domain. It recognises a six-step unlock pattern made of consecutive qualified reads. The first five reads go to fixed prefix addresses that all commands share. The sixth read selects one of four commands: store, recall, set the automatic-store inhibit, or clear it. The chosen command is signalled by a one-cycle pulse on its own output.

An access is counted only on a cycle in which the access-complete strobe is high and the chip is selected. Any selected access that does not continue the pattern ends the match, and then no command is issued. While the controller reports busy, or while the supply is low, the detector ignores the bus and returns to idle.

Top module: `seqcmd_detector`

## Requirements
- R1: While reset is asserted and after it is released, all four command outputs are low and the matcher is idle.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, then a read of 0x8FC0, raise `cmd_store` for exactly one cycle: the cycle after the clock edge that sampled the sixth strobe.
- R3: The same five prefix reads followed by a read of 0x4C63 raise `cmd_recall` for exactly one cycle, with the timing of R2.
- R4: The five prefix reads followed by 0x8B45 raise `cmd_inhibit_set`. Followed by 0x4B46 they raise `cmd_inhibit_clr`. Each pulse lasts one cycle, with the timing of R2.
- R5: Only address bits 15:0 are compared. Bit 16 has no effect on matching or on which command is issued.
- R6: A selected write (`ce_n`=0, `we_n`=0, strobe high) at any point in the pattern returns the matcher to idle, so no command follows.
- R7: A selected read that is not the next expected address, or a selected access with `oe_n` high, ends the pattern and no command is issued.
- R8: A qualified read of 0x4E38 always leaves the matcher at step one, including when that read ends a partial pattern. The next five reads can then complete a command.
- R9: A strobe while `ce_n` is high, and any cycle without the strobe, leave the pattern progress unchanged.
- R10: While `busy` or `pwr_low` is high, no access is counted, no command is issued, and the matcher goes back to idle.
- R11: At most one command output is high in any cycle. A command output is high only in the cycle after a sampled qualified read.
- R12: A sixth read to an address that is not one of the four command addresses issues nothing. Matching then starts again from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 17 | Sampled access address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| acc_done | input | 1 | High for one cycle when an access completes |
| busy | input | 1 | A nonvolatile operation is in progress |
| pwr_low | input | 1 | Supply below the operating threshold |
| cmd_store | output | 1 | Store command pulse |
| cmd_recall | output | 1 | Recall command pulse |
| cmd_inhibit_set | output | 1 | Inhibit-set command pulse |
| cmd_inhibit_clr | output | 1 | Inhibit-clear command pulse |

## Verification
Every command pulse comes out of a single register. It is therefore due in the cycle that follows the rising edge at which the sixth strobe was sampled, and it is gone one cycle later. The effect of an abort, a hold or a restart appears only through the pulse, or its absence, at that same point. The bench drives inputs on the falling edge and steps a behavioural model at each rising edge. It compares all four outputs with the model at every falling edge, so every output is checked in the exact cycle it is due, and also in the cycles where it must stay low.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMDS   = 4;
  localparam int KEY_BITS   = 16;

  typedef enum logic [1:0] {
    CMD_STORE   = 2'd0,
    CMD_RECALL  = 2'd1,
    CMD_INH_SET = 2'd2,
    CMD_INH_CLR = 2'd3
  } cmd_e;

  // Shared prefix, in the order it must be read.
  function automatic logic [KEY_BITS-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 16'h4E38;
      1:       prefix_key = 16'hB1C7;
      2:       prefix_key = 16'h83E0;
      3:       prefix_key = 16'h7C1F;
      default: prefix_key = 16'h703F;
    endcase
  endfunction

  // Sixth address for each command.
  function automatic logic [KEY_BITS-1:0] final_key(input int idx);
    case (idx)
      0:       final_key = 16'h8FC0;
      1:       final_key = 16'h4C63;
      2:       final_key = 16'h8B45;
      default: final_key = 16'h4B46;
    endcase
  endfunction

endpackage

// File: rtl/seqcmd_access_qual.sv
module seqcmd_access_qual #(
  parameter int KEY_W = 16
) (
  input  logic             acc_done,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             busy,
  input  logic             pwr_low,
  output logic             hold,
  output logic             rd_valid,
  output logic             abort_acc
);

  logic selected;
  logic read_kind;

  always_comb begin
    hold      = busy | pwr_low;
    selected  = acc_done & ~ce_n;
    read_kind = ~oe_n & we_n;
    rd_valid  = selected & read_kind & ~hold;
    abort_acc = selected & ~read_kind & ~hold;
  end

endmodule

// File: rtl/seqcmd_final_decode.sv
module seqcmd_final_decode
  import seqcmd_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int N_CMD = 4
) (
  input  logic [KEY_W-1:0] key,
  output logic [N_CMD-1:0] hit_vec,
  output logic             any_hit
);

  for (genvar c = 0; c < N_CMD; c++) begin : g_cmp
    assign hit_vec[c] = (key == KEY_W'(final_key(c)));
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/seqcmd_step_fsm.sv
module seqcmd_step_fsm
  import seqcmd_pkg::*;
#(
  parameter int KEY_W  = 16,
  parameter int N_PFX  = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rd_valid,
  input  logic              abort_acc,
  input  logic [KEY_W-1:0]  key,
  input  logic              final_hit,
  output logic [STEP_W-1:0] step_q,
  output logic              fire
);

  logic [N_PFX-1:0]  pfx_hit;
  logic              step_match;
  logic              at_final;
  logic              step_en;
  logic [STEP_W-1:0] step_d;

  for (genvar i = 0; i < N_PFX; i++) begin : g_pfx
    assign pfx_hit[i] = (key == KEY_W'(prefix_key(i)));
  end

  always_comb begin
    step_match = 1'b0;
    for (int i = 0; i < N_PFX; i++) begin
      if (step_q == STEP_W'(i) && pfx_hit[i]) step_match = 1'b1;
    end
  end

  assign at_final = (step_q == STEP_W'(N_PFX));
  assign fire     = rd_valid & at_final & final_hit;
  assign step_en  = hold | rd_valid | abort_acc;

  always_comb begin
    step_d = step_q;
    if (hold) begin
      step_d = '0;
    end else if (rd_valid) begin
      if (step_match)      step_d = step_q + STEP_W'(1);
      else if (fire)       step_d = '0;
      else if (pfx_hit[0]) step_d = STEP_W'(1);
      else                 step_d = '0;
    end else if (abort_acc) begin
      step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

endmodule

// File: rtl/seqcmd_detector.sv
module seqcmd_detector
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int KEY_W  = 16,
  parameter int N_PFX  = PREFIX_LEN,
  parameter int N_CMD  = NUM_CMDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              acc_done,
  input  logic              busy,
  input  logic              pwr_low,
  output logic              cmd_store,
  output logic              cmd_recall,
  output logic              cmd_inhibit_set,
  output logic              cmd_inhibit_clr
);

  localparam int STEP_W = $clog2(N_PFX + 1);

  logic [KEY_W-1:0]  key;
  logic              hold;
  logic              rd_valid;
  logic              abort_acc;
  logic [N_CMD-1:0]  hit_vec;
  logic              any_hit;
  logic [STEP_W-1:0] step_q;
  logic              fire;
  logic [N_CMD-1:0]  cmd_d;
  logic [N_CMD-1:0]  cmd_q;

  assign key = addr[KEY_W-1:0];

  seqcmd_access_qual #(.KEY_W(KEY_W)) u_qual (
    .acc_done  (acc_done),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy      (busy),
    .pwr_low   (pwr_low),
    .hold      (hold),
    .rd_valid  (rd_valid),
    .abort_acc (abort_acc)
  );

  seqcmd_final_decode #(.KEY_W(KEY_W), .N_CMD(N_CMD)) u_dec (
    .key     (key),
    .hit_vec (hit_vec),
    .any_hit (any_hit)
  );

  seqcmd_step_fsm #(.KEY_W(KEY_W), .N_PFX(N_PFX), .STEP_W(STEP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .rd_valid  (rd_valid),
    .abort_acc (abort_acc),
    .key       (key),
    .final_hit (any_hit),
    .step_q    (step_q),
    .fire      (fire)
  );

  always_comb begin
    cmd_d = '0;
    if (fire) cmd_d = hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign cmd_store       = cmd_q[int'(CMD_STORE)];
  assign cmd_recall      = cmd_q[int'(CMD_RECALL)];
  assign cmd_inhibit_set = cmd_q[int'(CMD_INH_SET)];
  assign cmd_inhibit_clr = cmd_q[int'(CMD_INH_CLR)];

endmodule

// File: rtl/seqcmd_checker.sv
module seqcmd_checker
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int KEY_W  = 16,
  parameter int N_PFX  = 5,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              acc_done,
  input logic              busy,
  input logic              pwr_low,
  input logic              cmd_store,
  input logic              cmd_recall,
  input logic              cmd_inhibit_set,
  input logic              cmd_inhibit_clr,
  input logic [STEP_W-1:0] step
);

  localparam logic [ADDR_W-1:0] KEY_MASK = ADDR_W'({KEY_W{1'b1}});

  logic any_cmd;
  logic good_rd;
  logic held;

  assign any_cmd = cmd_store | cmd_recall | cmd_inhibit_set | cmd_inhibit_clr;
  assign held    = busy | pwr_low;
  assign good_rd = acc_done & ~ce_n & ~oe_n & we_n & ~held;

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_store, cmd_recall, cmd_inhibit_set, cmd_inhibit_clr}));

  // R11
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> $past(good_rd));

  // R2 R5
  store_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_store |-> (($past(addr) & KEY_MASK) == ADDR_W'(final_key(0)))
                  && ($past(step) == STEP_W'(N_PFX)));

  // R3
  recall_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_recall |-> (($past(addr) & KEY_MASK) == ADDR_W'(final_key(1))));

  // R4
  inh_set_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_inhibit_set |-> (($past(addr) & KEY_MASK) == ADDR_W'(final_key(2))));

  // R4
  inh_clr_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_inhibit_clr |-> (($past(addr) & KEY_MASK) == ADDR_W'(final_key(3))));

  // R6
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !ce_n && !we_n && !held) |=> (step == '0));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_rd && ((addr & KEY_MASK) == ADDR_W'(prefix_key(0)))) |=> (step == STEP_W'(1)));

  // R9
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!acc_done || ce_n) && !held) |=> $stable(step));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ((step == '0) && !any_cmd));

endmodule

bind seqcmd_detector seqcmd_checker #(
  .ADDR_W(ADDR_W), .KEY_W(KEY_W), .N_PFX(N_PFX), .STEP_W(STEP_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .addr            (addr),
  .ce_n            (ce_n),
  .oe_n            (oe_n),
  .we_n            (we_n),
  .acc_done        (acc_done),
  .busy            (busy),
  .pwr_low         (pwr_low),
  .cmd_store       (cmd_store),
  .cmd_recall      (cmd_recall),
  .cmd_inhibit_set (cmd_inhibit_set),
  .cmd_inhibit_clr (cmd_inhibit_clr),
  .step            (step_q)
);

// File: tb/tb_seqcmd_detector.sv
`timescale 1ns/1ps
module tb_seqcmd_detector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        acc_done = 1'b0, busy = 1'b0, pwr_low = 1'b0;
  logic        cmd_store, cmd_recall, cmd_inhibit_set, cmd_inhibit_clr;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string cur_req = "R1";

  int unsigned pfx[$]  = '{32'h4E38, 32'hB1C7, 32'h83E0, 32'h7C1F, 32'h703F};
  int unsigned fins[$] = '{32'h8FC0, 32'h4C63, 32'h8B45, 32'h4B46};

  int         m_step = 0;
  logic [3:0] exp_cmd = '0;

  always #4 clk = ~clk;

  seqcmd_detector dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .acc_done(acc_done), .busy(busy), .pwr_low(pwr_low),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall),
    .cmd_inhibit_set(cmd_inhibit_set), .cmd_inhibit_clr(cmd_inhibit_clr)
  );

  // Behavioural reference, stepped on each rising edge.
  always @(posedge clk) begin
    int unsigned k;
    exp_cmd = '0;
    k = int'(addr[15:0]);
    if (!rst_n || busy || pwr_low) begin
      m_step = 0;
    end else if (acc_done && !ce_n) begin
      if (!oe_n && we_n) begin
        if (m_step < 5 && k == pfx[m_step]) m_step++;
        else if (m_step == 5 && k inside {fins}) begin
          for (int c = 0; c < 4; c++) if (k == fins[c]) exp_cmd[c] = 1'b1;
          m_step = 0;
        end else m_step = (k == pfx[0]) ? 1 : 0;
      end else m_step = 0;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    logic [3:0] act;
    act = {cmd_inhibit_clr, cmd_inhibit_set, cmd_recall, cmd_store};
    checks++;
    if (act !== exp_cmd) begin
      failures++;
      $display("FAIL %s: cmd actual=%b expected=%b at cycle %0d", cur_req, act, exp_cmd, cycles);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic access(input logic [16:0] a, input logic c, input logic o, input logic w);
    @(negedge clk);
    addr = a; ce_n = c; oe_n = o; we_n = w; acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a);
    access(a, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic prefix(input int upto);
    for (int i = 0; i < upto; i++) rd(17'(pfx[i]));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(3);

    cur_req = "R2";  prefix(5); rd(17'h08FC0); idle(3);
    cur_req = "R3";  prefix(5); rd(17'h04C63); idle(3);
    cur_req = "R4";  prefix(5); rd(17'h08B45); idle(2);
                     prefix(5); rd(17'h04B46); idle(3);
    cur_req = "R5";  for (int i = 0; i < 5; i++) rd(17'(pfx[i]) | 17'h10000);
                     rd(17'h18FC0); idle(3);
    cur_req = "R6";  prefix(3); access(17'h07C1F, 1'b0, 1'b1, 1'b0);
                     rd(17'h0703F); rd(17'h08FC0); idle(2);
                     prefix(5); access(17'h08FC0, 1'b0, 1'b1, 1'b0); idle(3);
    cur_req = "R7";  prefix(2); rd(17'h01234); rd(17'h07C1F); idle(2);
                     prefix(4); access(17'h0703F, 1'b0, 1'b1, 1'b1);
                     rd(17'h0703F); rd(17'h04C63); idle(3);
    cur_req = "R8";  prefix(2); prefix(5); rd(17'h08FC0); idle(2);
                     prefix(4); rd(17'h04E38); prefix(5); rd(17'h04C63); idle(3);
    cur_req = "R9";  prefix(3); access(17'h05555, 1'b1, 1'b0, 1'b0);
                     @(negedge clk); addr = 17'h01111; ce_n = 1'b0; oe_n = 1'b0; idle(2);
                     ce_n = 1'b1; oe_n = 1'b1;
                     rd(17'h07C1F); rd(17'h0703F); rd(17'h08B45); idle(3);
    cur_req = "R10"; prefix(4); @(negedge clk); busy = 1'b1; idle(2); busy = 1'b0;
                     rd(17'h0703F); rd(17'h08FC0); idle(2);
                     prefix(5); @(negedge clk); pwr_low = 1'b1;
                     addr = 17'h08FC0; ce_n = 1'b0; oe_n = 1'b0; acc_done = 1'b1;
                     @(negedge clk); acc_done = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
                     pwr_low = 1'b0; idle(3);
    cur_req = "R12"; prefix(5); rd(17'h01234); rd(17'h08FC0); idle(2);
                     prefix(5); rd(17'h04B46); idle(3);
    cur_req = "R11"; prefix(5); rd(17'h08FC0); prefix(5); rd(17'h04C63); idle(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule